// File: doc/BRIEF.md
# CAN Transmit Mailbox Arbiter

This block keeps a small bank of transmit mailboxes and decides which one the CAN transmit engine sends next. Software fills a mailbox through two write ports. The first is a control/status port that carries the state code, length, frame-format bit and remote-request bit. The second is a body port that carries the identifier and eight payload bytes. A mailbox takes part in selection only while its code is the active-send value. Selection follows one of two policies. In lowest-index mode the lowest-numbered candidate wins. In priority mode the candidate whose on-wire arbitration key is numerically smallest wins.

Selection does not run all the time. It runs only on these trigger strobes: the CRC and error-delimiter phases, a control/status write while the bus is quiet, and leaving freeze. Intermission also triggers it, but only in two conditional cases. The chosen mailbox is copied into a staging register that software cannot reach, and the transmit engine sends from there. When the engine reports success, the block writes back the timer value captured at identifier start, returns the mailbox code to inactive, and sets that mailbox's flag. The interrupt for a mailbox is the AND of its flag and its mask bit.

Top module: `cmb_tx_arbiter`

## Requirements
- R1: Only a mailbox whose code is 4'b1100 can be staged. Codes 4'b1000 and 4'b0000 are never chosen, and a mailbox that is already staged is not a candidate.
- R2: With `cfg_lowest_first`=1 the lowest-numbered candidate is staged.
- R3: With `cfg_lowest_first`=0 the candidate with the smallest 32-bit key is staged, and ties go to the lower index. For a standard frame (ide=0) the key holds id[28:18] in bits 31..21, RTR in bit 20, and zeros below. For an extended frame (ide=1) the key holds id[28:18] in bits 31..21, a 1 in bit 20, a 1 in bit 19, id[17:0] in bits 18..1, and RTR in bit 0. The key is shown on `stage_key`.
- R4: Selection is triggered by `ev_crc`, `ev_err_delim` or `ev_freeze_exit`, or by a control/status write while `bus_quiet`=1. A control/status write while `bus_quiet`=0 triggers nothing.
- R5: `ev_intermission` triggers selection only in two cases. The first is that the pending winner was withdrawn. The second is that the last selection found no candidate and a control/status write has occurred since that selection. In any other state intermission has no effect.
- R6: Any control/status write to the pending winner before move-out withdraws it, and nothing is staged until the next trigger.
- R7: A trigger strobe in cycle c makes `stage_valid`, `stage_idx`, `stage_key` and `stage_data` valid after the third rising edge, provided the stage was free. A winner found while the stage is busy waits until the stage is released.
- R8: `stage_nbytes` is the DLC clamped to 8.
- R9: On `tx_ok` the staged mailbox's stamp becomes the `timer` value latched on the last `ev_id_start`, its code becomes 4'b1000, its flag bit is set, and the stage is released.
- R10: `irq[i]` = `flags[i]` AND `imask[i]`. Writing a 1 to a bit of `flag_clr` clears that flag.
- R11: `tx_abort` releases the stage. The mailbox stays active and can be chosen by a later trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lowest_first | input | 1 | 1: lowest index wins; 0: smallest key wins |
| cs_we | input | 1 | Control/status write strobe |
| cs_idx | input | 4 | Mailbox addressed by the control/status write |
| cs_code | input | 4 | State code written |
| cs_dlc | input | 4 | Data length code written |
| cs_ide | input | 1 | Extended-format bit written |
| cs_rtr | input | 1 | Remote-request bit written |
| body_we | input | 1 | Identifier/payload write strobe |
| body_idx | input | 4 | Mailbox addressed by the body write |
| body_id | input | 29 | Identifier (standard id in bits 28..18) |
| body_data | input | 64 | Payload bytes |
| ev_crc | input | 1 | Bus is in the CRC field |
| ev_err_delim | input | 1 | Bus is in the error delimiter |
| ev_intermission | input | 1 | Bus is in intermission |
| ev_freeze_exit | input | 1 | Controller leaves freeze |
| bus_quiet | input | 1 | Controller idle or bus-off |
| ev_id_start | input | 1 | Identifier field starts; latch timer |
| timer | input | 16 | Free-running timer |
| tx_ok | input | 1 | Staged frame sent successfully |
| tx_abort | input | 1 | Staged frame given up; release stage |
| imask | input | 16 | Per-mailbox interrupt mask |
| flag_clr | input | 16 | Write-one-to-clear for flags |
| rd_idx | input | 4 | Mailbox shown on the read outputs |
| rd_code | output | 4 | Code of mailbox `rd_idx` |
| rd_stamp | output | 16 | Stamp of mailbox `rd_idx` |
| flags | output | 16 | Per-mailbox completion flags |
| irq | output | 16 | Masked per-mailbox interrupts |
| stage_valid | output | 1 | Staging register holds a frame |
| stage_idx | output | 4 | Mailbox that was staged |
| stage_key | output | 32 | On-wire arbitration key of the staged frame |
| stage_nbytes | output | 4 | Payload byte count, at most 8 |
| stage_data | output | 64 | Staged payload |

## Verification
A sweep loads many mixed mailbox banks under both policies and checks every staged result against a bench model. The banks include inactive codes, duplicate keys, mixed frame formats and RTR settings, and DLC values above 8. A design that packed RTR or IDE in the wrong key position, or that broke ties toward the higher index, would stage the wrong mailbox. Directed sequences cover three cases. One withdraws a pending winner while the stage is busy; a design that ignored the withdrawal would send a deactivated frame. One checks that intermission stays silent when neither of its two conditions holds; a design that always triggered would restage an aborted frame. One checks that a control/status write on a busy bus starts no selection.

// File: rtl/cmb_pkg.sv
package cmb_pkg;

    localparam int ID_W   = 29;
    localparam int KEY_W  = 32;
    localparam int DATA_W = 64;
    localparam int CODE_W = 4;
    localparam int DLC_W  = 4;

    typedef logic [CODE_W-1:0] mb_code_t;

    localparam mb_code_t CODE_OFF     = 4'b0000;
    localparam mb_code_t CODE_TX_IDLE = 4'b1000;
    localparam mb_code_t CODE_TX_SEND = 4'b1100;

    typedef struct packed {
        logic [ID_W-1:0]  id;
        logic             ide;
        logic             rtr;
        logic [DLC_W-1:0] dlc;
    } mb_hdr_t;

    // Arbitration key laid out as the bits go out on the wire (dominant 0 wins).
    function automatic logic [KEY_W-1:0] wire_key(mb_hdr_t h);
        logic [KEY_W-1:0] k;
        if (h.ide)
            k = {h.id[28:18], 1'b1, 1'b1, h.id[17:0], h.rtr};
        else
            k = {h.id[28:18], h.rtr, 1'b0, 18'd0, 1'b0};
        return k;
    endfunction

    function automatic logic [DLC_W-1:0] payload_len(logic [DLC_W-1:0] dlc);
        return (dlc > 4'd8) ? 4'd8 : dlc;
    endfunction

endpackage

// File: rtl/cmb_pick.sv
module cmb_pick
    import cmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int IW = $clog2(NUM_MB)
) (
    input  logic                          lowest_first,
    input  logic [NUM_MB-1:0]             cand,
    input  logic [NUM_MB-1:0][KEY_W-1:0]  keys,
    output logic                          found,
    output logic [IW-1:0]                 idx
);

    logic [KEY_W-1:0] best;

    // Linear scan; a strict less-than keeps the lower index on equal keys.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (cand[i]) begin
                if (!found || (!lowest_first && (keys[i] < best))) begin
                    found = 1'b1;
                    idx   = IW'(i);
                    best  = keys[i];
                end
            end
        end
    end

endmodule

// File: rtl/cmb_trig.sv
module cmb_trig (
    input  logic clk,
    input  logic rst,
    input  logic ev_crc,
    input  logic ev_err_delim,
    input  logic ev_intermission,
    input  logic ev_freeze_exit,
    input  logic bus_quiet,
    input  logic cs_we,
    input  logic win_lost,
    input  logic arb_now,
    input  logic arb_empty,
    output logic trig_q
);

    logic lost_q;
    logic empty_q;
    logic cs_since_q;
    logic fire_c;

    always_comb begin
        fire_c = ev_crc | ev_err_delim | ev_freeze_exit
               | (bus_quiet & cs_we)
               | (ev_intermission & (lost_q | (empty_q & cs_since_q)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q     <= 1'b0;
            lost_q     <= 1'b0;
            empty_q    <= 1'b0;
            cs_since_q <= 1'b0;
        end else begin
            trig_q <= fire_c;
            if (win_lost)
                lost_q <= 1'b1;
            else if (arb_now)
                lost_q <= 1'b0;
            if (arb_now)
                empty_q <= arb_empty;
            if (cs_we)
                cs_since_q <= 1'b1;
            else if (arb_now)
                cs_since_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cmb_tx_arbiter.sv
module cmb_tx_arbiter
    import cmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int TS_W   = 16,
    localparam int IW = $clog2(NUM_MB)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_lowest_first,
    input  logic                 cs_we,
    input  logic [IW-1:0]        cs_idx,
    input  logic [CODE_W-1:0]    cs_code,
    input  logic [DLC_W-1:0]     cs_dlc,
    input  logic                 cs_ide,
    input  logic                 cs_rtr,
    input  logic                 body_we,
    input  logic [IW-1:0]        body_idx,
    input  logic [ID_W-1:0]      body_id,
    input  logic [DATA_W-1:0]    body_data,
    input  logic                 ev_crc,
    input  logic                 ev_err_delim,
    input  logic                 ev_intermission,
    input  logic                 ev_freeze_exit,
    input  logic                 bus_quiet,
    input  logic                 ev_id_start,
    input  logic [TS_W-1:0]      timer,
    input  logic                 tx_ok,
    input  logic                 tx_abort,
    input  logic [NUM_MB-1:0]    imask,
    input  logic [NUM_MB-1:0]    flag_clr,
    input  logic [IW-1:0]        rd_idx,
    output logic [CODE_W-1:0]    rd_code,
    output logic [TS_W-1:0]      rd_stamp,
    output logic [NUM_MB-1:0]    flags,
    output logic [NUM_MB-1:0]    irq,
    output logic                 stage_valid,
    output logic [IW-1:0]        stage_idx,
    output logic [KEY_W-1:0]     stage_key,
    output logic [DLC_W-1:0]     stage_nbytes,
    output logic [DATA_W-1:0]    stage_data
);

    // Mailbox storage
    mb_code_t [NUM_MB-1:0]              code_q;
    mb_hdr_t  [NUM_MB-1:0]              hdr_q;
    logic     [NUM_MB-1:0][DATA_W-1:0]  data_q;
    logic     [NUM_MB-1:0][TS_W-1:0]    stamp_q;
    logic     [NUM_MB-1:0]              flag_q;
    logic     [TS_W-1:0]                ts_lat;

    // Selection
    logic [NUM_MB-1:0]             cand;
    logic [NUM_MB-1:0][KEY_W-1:0]  keys;
    logic                          pick_found;
    logic [IW-1:0]                 pick_idx;
    logic                          trig_q;
    logic                          win_valid;
    logic [IW-1:0]                 win_idx;
    logic                          win_active;
    logic                          win_lost;
    logic                          move_out;
    logic                          done;
    logic [NUM_MB-1:0]             done_vec;

    generate
        for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
            assign keys[g] = wire_key(hdr_q[g]);
            assign cand[g] = (code_q[g] == CODE_TX_SEND)
                           && !(stage_valid && (stage_idx == IW'(g)));
        end
    endgenerate

    cmb_pick #(.NUM_MB(NUM_MB)) u_pick (
        .lowest_first (cfg_lowest_first),
        .cand         (cand),
        .keys         (keys),
        .found        (pick_found),
        .idx          (pick_idx)
    );

    cmb_trig u_trig (
        .clk             (clk),
        .rst             (rst),
        .ev_crc          (ev_crc),
        .ev_err_delim    (ev_err_delim),
        .ev_intermission (ev_intermission),
        .ev_freeze_exit  (ev_freeze_exit),
        .bus_quiet       (bus_quiet),
        .cs_we           (cs_we),
        .win_lost        (win_lost),
        .arb_now         (trig_q),
        .arb_empty       (trig_q && !pick_found),
        .trig_q          (trig_q)
    );

    // Any control/status write to the pending winner withdraws it.
    always_comb begin
        win_active = (code_q[win_idx] == CODE_TX_SEND) && !(cs_we && (cs_idx == win_idx));
        win_lost   = win_valid && !trig_q && !win_active;
        move_out   = win_valid && !trig_q && win_active && !stage_valid;
        done       = tx_ok && stage_valid;
        done_vec   = done ? (NUM_MB'(1) << stage_idx) : '0;
    end

    // Mailbox bank
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            hdr_q   <= '0;
            data_q  <= '0;
            stamp_q <= '0;
            flag_q  <= '0;
            ts_lat  <= '0;
        end else begin
            if (cs_we) begin
                code_q[cs_idx]    <= cs_code;
                hdr_q[cs_idx].dlc <= cs_dlc;
                hdr_q[cs_idx].ide <= cs_ide;
                hdr_q[cs_idx].rtr <= cs_rtr;
            end
            if (body_we) begin
                hdr_q[body_idx].id <= body_id;
                data_q[body_idx]   <= body_data;
            end
            if (done) begin
                code_q[stage_idx]  <= CODE_TX_IDLE;
                stamp_q[stage_idx] <= ts_lat;
            end
            if (ev_id_start)
                ts_lat <= timer;
            flag_q <= (flag_q & ~flag_clr) | done_vec;
        end
    end

    // Winner register and staging buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid    <= 1'b0;
            win_idx      <= '0;
            stage_valid  <= 1'b0;
            stage_idx    <= '0;
            stage_key    <= '0;
            stage_nbytes <= '0;
            stage_data   <= '0;
        end else begin
            if (trig_q) begin
                win_valid <= pick_found;
                win_idx   <= pick_idx;
            end else if (win_lost || move_out) begin
                win_valid <= 1'b0;
            end

            if (move_out) begin
                stage_valid  <= 1'b1;
                stage_idx    <= win_idx;
                stage_key    <= keys[win_idx];
                stage_nbytes <= payload_len(hdr_q[win_idx].dlc);
                stage_data   <= data_q[win_idx];
            end else if (stage_valid && (tx_ok || tx_abort)) begin
                stage_valid <= 1'b0;
            end
        end
    end

    assign rd_code  = code_q[rd_idx];
    assign rd_stamp = stamp_q[rd_idx];
    assign flags    = flag_q;
    assign irq      = flag_q & imask;

endmodule

// File: rtl/cmb_tx_arbiter_chk.sv
module cmb_tx_arbiter_chk
    import cmb_pkg::*;
#(
    parameter int NUM_MB = 16,
    parameter int TS_W   = 16,
    localparam int IW = $clog2(NUM_MB)
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           tx_ok,
    input logic                           tx_abort,
    input logic                           stage_valid,
    input logic [IW-1:0]                  stage_idx,
    input logic [DLC_W-1:0]               stage_nbytes,
    input logic [NUM_MB-1:0][CODE_W-1:0]  code_q,
    input logic [NUM_MB-1:0][TS_W-1:0]    stamp_q,
    input logic [NUM_MB-1:0]              flag_q,
    input logic [TS_W-1:0]                ts_lat
);

    logic [IW-1:0]   last_idx;
    logic [TS_W-1:0] last_ts;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_idx <= '0;
            last_ts  <= '0;
        end else begin
            last_idx <= stage_idx;
            last_ts  <= ts_lat;
        end
    end

    AST_STAGE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(stage_valid) |-> code_q[stage_idx] == CODE_TX_SEND); // R1

    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stage_valid && !tx_ok && !tx_abort) |=> (stage_valid && stage_idx == last_idx)); // R7

    AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (rst)
        stage_valid |-> stage_nbytes <= 4'd8); // R8

    AST_DONE_CODE: assert property (@(posedge clk) disable iff (rst)
        (tx_ok && stage_valid) |=> code_q[last_idx] == CODE_TX_IDLE); // R9

    AST_DONE_STAMP: assert property (@(posedge clk) disable iff (rst)
        (tx_ok && stage_valid) |=> stamp_q[last_idx] == last_ts); // R9

    AST_DONE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (tx_ok && stage_valid) |=> flag_q[last_idx]); // R9

    AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (tx_abort && stage_valid) |=> !stage_valid); // R11

endmodule

bind cmb_tx_arbiter cmb_tx_arbiter_chk #(.NUM_MB(NUM_MB), .TS_W(TS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tx_ok        (tx_ok),
    .tx_abort     (tx_abort),
    .stage_valid  (stage_valid),
    .stage_idx    (stage_idx),
    .stage_nbytes (stage_nbytes),
    .code_q       (code_q),
    .stamp_q      (stamp_q),
    .flag_q       (flag_q),
    .ts_lat       (ts_lat)
);

// File: tb/cmb_tx_arbiter_tb.sv
module cmb_tx_arbiter_tb;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_lowest_first;
    logic        cs_we;
    logic [3:0]  cs_idx;
    logic [3:0]  cs_code;
    logic [3:0]  cs_dlc;
    logic        cs_ide;
    logic        cs_rtr;
    logic        body_we;
    logic [3:0]  body_idx;
    logic [28:0] body_id;
    logic [63:0] body_data;
    logic        ev_crc, ev_err_delim, ev_intermission, ev_freeze_exit;
    logic        bus_quiet, ev_id_start, tx_ok, tx_abort;
    logic [15:0] timer;
    logic [N-1:0] imask, flag_clr;
    logic [3:0]  rd_idx;
    logic [3:0]  rd_code;
    logic [15:0] rd_stamp;
    logic [N-1:0] flags, irq;
    logic        stage_valid;
    logic [3:0]  stage_idx;
    logic [31:0] stage_key;
    logic [3:0]  stage_nbytes;
    logic [63:0] stage_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Bench copy of what was written
    logic [3:0]  m_code [N];
    logic [28:0] m_id   [N];
    logic        m_ide  [N];
    logic        m_rtr  [N];
    logic [3:0]  m_dlc  [N];
    logic [63:0] m_data [N];
    logic [31:0] rng = 32'h1357_9BDF;

    always #10 clk = ~clk;

    cmb_tx_arbiter u_dut (
        .clk(clk), .rst(rst), .cfg_lowest_first(cfg_lowest_first),
        .cs_we(cs_we), .cs_idx(cs_idx), .cs_code(cs_code), .cs_dlc(cs_dlc),
        .cs_ide(cs_ide), .cs_rtr(cs_rtr),
        .body_we(body_we), .body_idx(body_idx), .body_id(body_id), .body_data(body_data),
        .ev_crc(ev_crc), .ev_err_delim(ev_err_delim), .ev_intermission(ev_intermission),
        .ev_freeze_exit(ev_freeze_exit), .bus_quiet(bus_quiet), .ev_id_start(ev_id_start),
        .timer(timer), .tx_ok(tx_ok), .tx_abort(tx_abort), .imask(imask), .flag_clr(flag_clr),
        .rd_idx(rd_idx), .rd_code(rd_code), .rd_stamp(rd_stamp), .flags(flags), .irq(irq),
        .stage_valid(stage_valid), .stage_idx(stage_idx), .stage_key(stage_key),
        .stage_nbytes(stage_nbytes), .stage_data(stage_data)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_key(input logic [28:0] id, input logic ide, input logic rtr);
        logic [31:0] base;
        base = 32'(id[28:18]) * 32'd2097152;
        if (ide)
            return base + 32'd1048576 + 32'd524288 + 32'(id[17:0]) * 32'd2 + 32'(rtr);
        return base + 32'(rtr) * 32'd1048576;
    endfunction

    task automatic step_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    task automatic wr_mb(input int i, input logic [3:0] code, input logic [3:0] dlc,
                         input logic ide, input logic rtr, input logic [28:0] id,
                         input logic [63:0] data);
        cs_we = 1; cs_idx = 4'(i); cs_code = code; cs_dlc = dlc; cs_ide = ide; cs_rtr = rtr;
        body_we = 1; body_idx = 4'(i); body_id = id; body_data = data;
        m_code[i] = code; m_dlc[i] = dlc; m_ide[i] = ide; m_rtr[i] = rtr;
        m_id[i] = id; m_data[i] = data;
        tick(1);
        cs_we = 0; body_we = 0;
    endtask

    task automatic wr_code(input int i, input logic [3:0] code);
        cs_we = 1; cs_idx = 4'(i); cs_code = code; cs_dlc = m_dlc[i];
        cs_ide = m_ide[i]; cs_rtr = m_rtr[i];
        m_code[i] = code;
        tick(1);
        cs_we = 0;
    endtask

    // 0 crc, 1 err delim, 2 intermission, 3 freeze exit, 4 id start, 5 ok, 6 abort
    task automatic pulse(input int which);
        case (which)
            0: ev_crc = 1;
            1: ev_err_delim = 1;
            2: ev_intermission = 1;
            3: ev_freeze_exit = 1;
            4: ev_id_start = 1;
            5: tx_ok = 1;
            default: tx_abort = 1;
        endcase
        tick(1);
        ev_crc = 0; ev_err_delim = 0; ev_intermission = 0; ev_freeze_exit = 0;
        ev_id_start = 0; tx_ok = 0; tx_abort = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_lowest_first = 0;
        cs_we = 0; cs_idx = 0; cs_code = 0; cs_dlc = 0; cs_ide = 0; cs_rtr = 0;
        body_we = 0; body_idx = 0; body_id = 0; body_data = 0;
        ev_crc = 0; ev_err_delim = 0; ev_intermission = 0; ev_freeze_exit = 0;
        bus_quiet = 0; ev_id_start = 0; tx_ok = 0; tx_abort = 0;
        timer = 0; imask = 0; flag_clr = 0; rd_idx = 0;
        for (int i = 0; i < N; i++) begin
            m_code[i] = 0; m_id[i] = 0; m_ide[i] = 0; m_rtr[i] = 0; m_dlc[i] = 0; m_data[i] = 0;
        end
        tick(3);
        rst = 0;
        tick(1);

        check("R9", "reset stage_valid", 64'(stage_valid), 64'd0);
        check("R10", "reset flags", 64'(flags), 64'd0);
        check("R10", "reset irq", 64'(irq), 64'd0);
        check("R1", "reset code", 64'(rd_code), 64'd0);

        // Sweep: both policies, mixed banks with duplicate keys and long DLCs
        for (int mode = 0; mode < 2; mode++) begin
            cfg_lowest_first = mode[0];
            for (int it = 0; it < 40; it++) begin
                int  ew;
                logic ef;
                logic [31:0] bk;
                for (int i = 0; i < N; i++) begin
                    logic [3:0]  c;
                    logic [28:0] id;
                    step_rng();
                    case (rng[9:8])
                        2'd0: c = 4'b0000;
                        2'd1: c = 4'b1000;
                        default: c = 4'b1100;
                    endcase
                    if (it % 7 == 3) c = 4'b1000;
                    id = {8'd0, rng[2:0], 16'd0, rng[5:4]};
                    wr_mb(i, c, rng[15:12], rng[6], rng[7], id, {rng, ~rng});
                end
                ef = 0; ew = 0; bk = 0;
                for (int i = 0; i < N; i++) begin
                    if (m_code[i] == 4'b1100) begin
                        logic [31:0] k;
                        k = ref_key(m_id[i], m_ide[i], m_rtr[i]);
                        if (!ef) begin ef = 1; ew = i; bk = k; end
                        else if (mode == 0 && k < bk) begin ew = i; bk = k; end
                    end
                end
                pulse(0);
                tick(2);
                if (!ef) begin
                    check("R1", "no candidate, stage_valid", 64'(stage_valid), 64'd0);
                end else begin
                    check(mode == 1 ? "R2" : "R3", "winner index", 64'(stage_idx), 64'(ew));
                    check("R3", "stage key", 64'(stage_key), 64'(ref_key(m_id[ew], m_ide[ew], m_rtr[ew])));
                    check("R8", "nbytes", 64'(stage_nbytes), 64'(m_dlc[ew] > 8 ? 4'd8 : m_dlc[ew]));
                    check("R7", "stage data", stage_data, m_data[ew]);
                    check("R7", "stage_valid", 64'(stage_valid), 64'd1);
                end
                pulse(6);
                tick(1);
            end
        end

        // Directed sequences in priority mode
        cfg_lowest_first = 0;
        for (int i = 0; i < N; i++) wr_mb(i, 4'b0000, 4'd0, 0, 0, 29'd0, 64'd0);
        wr_mb(2, 4'b1100, 4'd3, 0, 0, {11'h100, 18'd0}, 64'hAAAA);
        wr_mb(7, 4'b1100, 4'd4, 0, 0, {11'h200, 18'd0}, 64'hBBBB);
        pulse(0);
        tick(2);
        check("R7", "first stage index", 64'(stage_idx), 64'd2);
        // next winner chosen while stage busy, then withdrawn
        pulse(1);
        tick(1);
        check("R7", "busy stage holds", 64'(stage_idx), 64'd2);
        wr_code(7, 4'b1000);
        timer = 16'h3A5C;
        pulse(4);
        timer = 16'h0101;
        pulse(5);
        tick(3);
        check("R6", "withdrawn winner not staged", 64'(stage_valid), 64'd0);
        rd_idx = 2;
        tick(1);
        check("R9", "code after success", 64'(rd_code), 64'h8);
        check("R9", "timestamp", 64'(rd_stamp), 64'h3A5C);
        check("R9", "flag set", 64'(flags), 64'h4);
        check("R10", "masked irq", 64'(irq), 64'd0);
        imask = 16'h0004;
        tick(1);
        check("R10", "unmasked irq", 64'(irq), 64'h4);
        flag_clr = 16'h0004;
        tick(1);
        flag_clr = 0;
        check("R10", "flag cleared", 64'(flags), 64'd0);
        check("R10", "irq cleared", 64'(irq), 64'd0);
        imask = 0;

        wr_code(7, 4'b1100);
        tick(3);
        check("R4", "busy-bus write no trigger", 64'(stage_valid), 64'd0);
        pulse(2);
        tick(2);
        check("R5", "intermission after withdrawal", 64'(stage_valid), 64'd1);
        check("R6", "withdrawn buffer restaged", 64'(stage_idx), 64'd7);

        pulse(6);
        tick(1);
        pulse(2);
        tick(3);
        check("R5", "intermission ignored", 64'(stage_valid), 64'd0);
        rd_idx = 7;
        tick(1);
        check("R11", "aborted buffer stays active", 64'(rd_code), 64'hC);
        pulse(3);
        tick(2);
        check("R4", "freeze exit trigger", 64'(stage_idx), 64'd7);
        check("R11", "restaged after abort", 64'(stage_valid), 64'd1);
        pulse(6);
        tick(1);

        bus_quiet = 1;
        wr_mb(9, 4'b1100, 4'd2, 0, 1, {11'h050, 18'd0}, 64'hC0DE);
        tick(2);
        bus_quiet = 0;
        check("R4", "quiet write trigger", 64'(stage_idx), 64'd9);
        check("R3", "std rtr key", 64'(stage_key), 64'(ref_key({11'h050, 18'd0}, 0, 1)));
        pulse(6);
        tick(1);

        wr_code(7, 4'b1000);
        wr_code(9, 4'b1000);
        pulse(0);
        tick(3);
        check("R1", "empty selection", 64'(stage_valid), 64'd0);
        wr_mb(12, 4'b1100, 4'd13, 1, 0, {11'h3FF, 18'h2AAAA}, 64'h1122_3344_5566_7788);
        tick(2);
        check("R5", "no trigger before intermission", 64'(stage_valid), 64'd0);
        pulse(2);
        tick(2);
        check("R5", "intermission after empty + write", 64'(stage_idx), 64'd12);
        check("R8", "dlc 13 clamped", 64'(stage_nbytes), 64'd8);
        check("R3", "ext key", 64'(stage_key), 64'(ref_key({11'h3FF, 18'h2AAAA}, 1, 0)));

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule